// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor

This block is a 32-bit processor that retires one instruction on every rising clock edge. It handles nine instructions: word load and store, five register-to-register operations (add, subtract, and, or, signed set-less-than), branch-on-equal, and an unconditional jump. The instruction and data memories are word arrays inside the block. Inside it there are a program counter, a 32-entry register file, an ALU with a zero flag, a sign extender, the next-PC logic, and a control unit. The control unit has a main decoder and a second decoder that picks the ALU operation.

Both memories are filled through a preload port while reset is held. When reset is released, the core starts fetching at address 0. Two commit buses show each retired effect: one for register writes and one for memory writes. The current program counter is also an output, so a bench can follow execution one instruction at a time.

Top module: `cpu_core`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, the program counter is 0 at each clock edge and neither commit strobe is asserted. The first instruction after release is fetched from address 0.
- R2: Register-format instructions use opcode 000000 in bits 31:26. They read rs (bits 25:21) and rt (bits 20:16) and write rd (bits 15:11). The function field in bits 5:0 selects the operation: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 set-less-than.
- R3: Set-less-than compares its operands as signed 32-bit values and writes 1 or 0.
- R4: Function bits 5 and 4 have no effect. For example, function 010000 performs an add.
- R5: A load (opcode 100011) writes to rt the data word at address rs plus the sign-extended 16-bit displacement in bits 15:0. Negative displacements are included.
- R6: A store (opcode 101011) writes rt to data memory at rs plus the sign-extended displacement. It asserts no register write.
- R7: Branch-on-equal (opcode 000100) with equal registers sets the PC to PC+4 plus the sign-extended displacement shifted left by two. This covers backward targets.
- R8: Branch-on-equal with unequal registers, and every other non-jump instruction, moves the PC to PC+4. A not-taken branch writes nothing.
- R9: A jump (opcode 000010) sets the PC to the upper four bits of PC+4, then the 26-bit operand, then two zero bits.
- R10: Register 0 always reads as zero. A write that targets it is dropped and shows no register-write strobe.
- R11: An opcode outside the supported set writes no register and no memory, and the PC advances by 4.
- R12: A register read in the same cycle as a write to that register returns the old value. The new value is seen from the next instruction on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ldEn | input | 1 | Preload write strobe, used while in reset |
| ldDmem | input | 1 | Preload target: 1 for data memory, 0 for instruction memory |
| ldAddr | input | MEM_AW | Preload word index |
| ldData | input | 32 | Preload word |
| pcOut | output | 32 | Current program counter |
| regWe | output | 1 | A register write retires at the next edge |
| regWaddr | output | log2(NREG) | Destination register of that write |
| regWdata | output | 32 | Value being written |
| memWe | output | 1 | A data-memory write retires at the next edge |
| memAddr | output | 32 | Byte address of the data access |
| memWdata | output | 32 | Store data |

## Verification
The assertions assume that every instruction word that executes has been loaded. They also assume that memory byte addresses fall inside the arrays, because the upper address bits are not decoded. The preload strobe is assumed to pulse only while reset is held. The stimulus meets all three conditions. It loads every word of the program before release, keeps the computed addresses within the first few words, and drives the preload port only during reset. Branch and jump targets stay inside the loaded program. Skipped slots hold instructions whose execution would show up as a wrong PC or a stray write.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  typedef enum logic [5:0] {
    OP_RTYPE = 6'b000000,
    OP_JUMP  = 6'b000010,
    OP_BEQ   = 6'b000100,
    OP_LOAD  = 6'b100011,
    OP_STORE = 6'b101011
  } opcode_e;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } aluCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     destIsRd;
    logic     useImm;
    logic     loadToReg;
    logic     regWrite;
    logic     memRead;
    logic     memWrite;
    logic     isBranch;
    logic     isJump;
    aluCode_e aluCode;
  } ctrl_t;

endpackage

// File: rtl/cpu_control.sv
module cpu_control
  import cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  logic [1:0] aluClass;
  logic [1:0] unusedFunct;

  assign unusedFunct = funct[5:4];

  // first step: main decode of the opcode
  always_comb begin
    ctrl.destIsRd  = 1'b0;
    ctrl.useImm    = 1'b0;
    ctrl.loadToReg = 1'b0;
    ctrl.regWrite  = 1'b0;
    ctrl.memRead   = 1'b0;
    ctrl.memWrite  = 1'b0;
    ctrl.isBranch  = 1'b0;
    ctrl.isJump    = 1'b0;
    aluClass       = 2'b00;
    case (opcode)
      OP_RTYPE: begin
        ctrl.destIsRd = 1'b1;
        ctrl.regWrite = 1'b1;
        aluClass      = 2'b10;
      end
      OP_LOAD: begin
        ctrl.useImm    = 1'b1;
        ctrl.loadToReg = 1'b1;
        ctrl.regWrite  = 1'b1;
        ctrl.memRead   = 1'b1;
      end
      OP_STORE: begin
        ctrl.useImm   = 1'b1;
        ctrl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctrl.isBranch = 1'b1;
        aluClass      = 2'b01;
      end
      OP_JUMP: ctrl.isJump = 1'b1;
      default: ;
    endcase
  end

  // second step: ALU class plus function field
  always_comb begin
    case (aluClass)
      2'b00:   ctrl.aluCode = ALU_ADD;
      2'b01:   ctrl.aluCode = ALU_SUB;
      default: begin
        case (funct[3:0])
          4'b0000: ctrl.aluCode = ALU_ADD;
          4'b0010: ctrl.aluCode = ALU_SUB;
          4'b0100: ctrl.aluCode = ALU_AND;
          4'b0101: ctrl.aluCode = ALU_OR;
          4'b1010: ctrl.aluCode = ALU_SLT;
          default: ctrl.aluCode = ALU_ADD;
        endcase
      end
    endcase
  end

  // a store never retires a register write
  assert_store_noreg_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWrite |-> !ctrl.regWrite);

  // a branch compares by subtraction
  assert_branch_sub_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl.isBranch |-> (ctrl.aluCode == ALU_SUB && !ctrl.regWrite && !ctrl.memWrite));

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  aluCode_e     code,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (code)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : W'(0);
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] ra1,
  input  logic [RAW-1:0] ra2,
  input  logic [RAW-1:0] wa,
  input  logic [W-1:0]   wd,
  output logic [W-1:0]   rd1,
  output logic [W-1:0]   rd2
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import cpu_pkg::*;
#(
  parameter int MEM_AW = 6,
  parameter int NREG   = 32,
  localparam int RAW   = $clog2(NREG),
  localparam int WORDS = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  output logic [5:0]        opcode,
  output logic [5:0]        funct,
  input  logic              ldEn,
  input  logic              ldDmem,
  input  logic [MEM_AW-1:0] ldAddr,
  input  logic [31:0]       ldData,
  output logic [31:0]       pcOut,
  output logic              regWe,
  output logic [RAW-1:0]    regWaddr,
  output logic [31:0]       regWdata,
  output logic              memWe,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWdata
);

  logic [31:0] imem [WORDS];
  logic [31:0] dmem [WORDS];

  logic [31:0] pc, pcPlus4, brTarget, jTarget, pcNext;
  logic [31:0] instr, immExt, immShift;
  logic [31:0] rdA, rdB, srcB, aluY, readData, wbData;
  logic [RAW-1:0] rsIdx, rtIdx, rdIdx, destIdx;
  logic [4:0]  unusedShamt;
  logic        aluZero, takeBranch, wrEnable;

  // fetch and field split
  assign instr       = imem[pc[MEM_AW+1:2]];
  assign opcode      = instr[31:26];
  assign funct       = instr[5:0];
  assign rsIdx       = instr[25:21];
  assign rtIdx       = instr[20:16];
  assign rdIdx       = instr[15:11];
  assign unusedShamt = instr[10:6];
  assign immExt      = {{16{instr[15]}}, instr[15:0]};
  assign immShift    = immExt << 2;

  assign destIdx  = ctrl.destIsRd ? rdIdx : rtIdx;
  assign wrEnable = ctrl.regWrite && !rst;

  cpu_regfile #(.NREG(NREG), .W(32)) u_regs (
    .clk (clk),
    .we  (wrEnable),
    .ra1 (rsIdx),
    .ra2 (rtIdx),
    .wa  (destIdx),
    .wd  (wbData),
    .rd1 (rdA),
    .rd2 (rdB)
  );

  assign srcB = ctrl.useImm ? immExt : rdB;

  cpu_alu #(.W(32)) u_alu (
    .a    (rdA),
    .b    (srcB),
    .code (ctrl.aluCode),
    .y    (aluY),
    .zero (aluZero)
  );

  // data memory
  assign readData = ctrl.memRead ? dmem[aluY[MEM_AW+1:2]] : '0;
  assign wbData   = ctrl.loadToReg ? readData : aluY;

  always_ff @(posedge clk) begin
    if (ldEn && ldDmem) dmem[ldAddr] <= ldData;
    else if (ctrl.memWrite && !rst) dmem[aluY[MEM_AW+1:2]] <= rdB;
  end

  always_ff @(posedge clk) begin
    if (ldEn && !ldDmem) imem[ldAddr] <= ldData;
  end

  // next-PC selection
  assign pcPlus4    = pc + 32'd4;
  assign brTarget   = pcPlus4 + immShift;
  assign jTarget    = {pcPlus4[31:28], instr[25:0], 2'b00};
  assign takeBranch = ctrl.isBranch & aluZero;

  always_comb begin
    if (ctrl.isJump)     pcNext = jTarget;
    else if (takeBranch) pcNext = brTarget;
    else                 pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  // commit buses
  assign pcOut    = pc;
  assign regWe    = wrEnable && (destIdx != '0);
  assign regWaddr = destIdx;
  assign regWdata = wbData;
  assign memWe    = ctrl.memWrite && !rst;
  assign memAddr  = aluY;
  assign memWdata = rdB;

  assert_reset_pc_R1: assert property (@(posedge clk)
    rst |=> (pc == '0));

  assert_seq_pc_R8: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.isJump && !takeBranch) |=> (pc == $past(pc) + 32'd4));

  assert_branch_pc_R7: assert property (@(posedge clk) disable iff (rst)
    takeBranch |=> (pc == $past(pcPlus4) + $past(immShift)));

  assert_branch_eq_R7: assert property (@(posedge clk) disable iff (rst)
    takeBranch |-> (rdA == rdB));

  assert_jump_pc_R9: assert property (@(posedge clk) disable iff (rst)
    ctrl.isJump |=> (pc[27:2] == $past(instr[25:0]) && pc[1:0] == 2'b00));

  assert_zero_reg_R10: assert property (@(posedge clk) disable iff (rst)
    (rsIdx == '0) |-> (rdA == '0));

endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int MEM_AW = 6,
  parameter int NREG   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ldEn,
  input  logic                     ldDmem,
  input  logic [MEM_AW-1:0]        ldAddr,
  input  logic [31:0]              ldData,
  output logic [31:0]              pcOut,
  output logic                     regWe,
  output logic [$clog2(NREG)-1:0]  regWaddr,
  output logic [31:0]              regWdata,
  output logic                     memWe,
  output logic [31:0]              memAddr,
  output logic [31:0]              memWdata
);

  ctrl_t      ctrl;
  logic [5:0] opcode, funct;

  cpu_control u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  cpu_datapath #(.MEM_AW(MEM_AW), .NREG(NREG)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .opcode   (opcode),
    .funct    (funct),
    .ldEn     (ldEn),
    .ldDmem   (ldDmem),
    .ldAddr   (ldAddr),
    .ldData   (ldData),
    .pcOut    (pcOut),
    .regWe    (regWe),
    .regWaddr (regWaddr),
    .regWdata (regWdata),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

endmodule

// File: tb/cpu_core_bench.sv
`timescale 1ns/1ps
module cpu_core_bench;

  localparam int MEM_AW = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ldEn = 1'b0;
  logic              ldDmem = 1'b0;
  logic [MEM_AW-1:0] ldAddr = '0;
  logic [31:0]       ldData = '0;
  logic [31:0]       pcOut, regWdata, memAddr, memWdata;
  logic [4:0]        regWaddr;
  logic              regWe, memWe;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cpu_core #(.MEM_AW(MEM_AW), .NREG(32)) u_cpu_core (
    .clk(clk), .rst(rst), .ldEn(ldEn), .ldDmem(ldDmem), .ldAddr(ldAddr), .ldData(ldData),
    .pcOut(pcOut), .regWe(regWe), .regWaddr(regWaddr), .regWdata(regWdata),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  typedef struct {
    logic [31:0] pc;
    int          kind;   // 0 none, 1 register write, 2 memory write
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } item_t;

  item_t sb[$];

  function automatic logic [31:0] rIns(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
  endfunction
  function automatic logic [31:0] iIns(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] jIns(int target);
    return {6'b000010, 26'(target)};
  endfunction

  task automatic load(input bit toData, input int idx, input logic [31:0] w);
    @(negedge clk);
    ldEn = 1'b1; ldDmem = toData; ldAddr = MEM_AW'(idx); ldData = w;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic expectStep(input logic [31:0] pc, input int kind,
                            input logic [31:0] a, input logic [31:0] d, input string tag);
    item_t it;
    it.pc = pc; it.kind = kind; it.addr = a; it.data = d; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic check(input bit ok, input string tag, input string got, input string want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %s expected %s", tag, got, want);
    end
  endtask

  localparam logic [5:0] F_ADD = 6'b100000, F_SUB = 6'b100010, F_AND = 6'b100100,
                         F_OR  = 6'b100101, F_SLT = 6'b101010;
  localparam logic [5:0] O_LW = 6'b100011, O_SW = 6'b101011, O_BEQ = 6'b000100;

  // driver: preload, reset checks and expected commits
  initial begin
    load(1, 0, 32'd5);
    load(1, 1, 32'hFFFF_FFFD);
    load(1, 2, 32'd12);
    load(1, 3, 32'hF0F0_F0F0);
    load(0, 0,  iIns(O_LW, 0, 1, 0));
    load(0, 1,  iIns(O_LW, 0, 2, 4));
    load(0, 2,  iIns(O_LW, 0, 3, 8));
    load(0, 3,  iIns(O_LW, 3, 4, -8));
    load(0, 4,  rIns(1, 2, 5, F_ADD));
    load(0, 5,  rIns(1, 2, 6, F_SUB));
    load(0, 6,  rIns(1, 3, 7, F_AND));
    load(0, 7,  rIns(1, 3, 8, F_OR));
    load(0, 8,  rIns(2, 1, 9, F_SLT));
    load(0, 9,  rIns(1, 2, 10, F_SLT));
    load(0, 10, rIns(1, 3, 11, 6'b010000));
    load(0, 11, rIns(1, 1, 0, F_ADD));
    load(0, 12, iIns(O_SW, 0, 0, 16));
    load(0, 13, iIns(O_SW, 3, 8, 4));
    load(0, 14, iIns(O_LW, 0, 12, 16));
    load(0, 15, rIns(1, 1, 1, F_ADD));
    load(0, 16, rIns(1, 1, 1, F_ADD));
    load(0, 17, iIns(6'b111111, 0, 1, 4));
    load(0, 18, iIns(O_BEQ, 1, 2, 5));
    load(0, 19, iIns(O_BEQ, 5, 5, 2));
    load(0, 20, rIns(1, 1, 13, F_ADD));
    load(0, 21, rIns(1, 1, 13, F_ADD));
    load(0, 22, jIns(25));
    load(0, 23, iIns(O_SW, 1, 1, 0));
    load(0, 24, iIns(O_SW, 1, 1, 0));
    load(0, 25, jIns(30));
    load(0, 26, rIns(1, 1, 15, F_ADD));
    load(0, 27, rIns(1, 2, 14, F_ADD));
    load(0, 28, jIns(32));
    load(0, 29, rIns(1, 1, 15, F_ADD));
    load(0, 30, iIns(O_BEQ, 0, 0, -4));
    load(0, 31, rIns(1, 1, 15, F_ADD));
    load(0, 32, jIns(32));

    // R1: reset state
    @(negedge clk);
    check(pcOut == 32'd0, "R1 pc in reset", $sformatf("%0h", pcOut), "0");
    check(!regWe && !memWe, "R1 strobes in reset",
          $sformatf("%0b%0b", regWe, memWe), "00");

    expectStep(0,   1, 1,  32'd5,        "R5 lw base");
    expectStep(4,   1, 2,  32'hFFFFFFFD, "R5 lw offset");
    expectStep(8,   1, 3,  32'd12,       "R5 lw");
    expectStep(12,  1, 4,  32'hFFFFFFFD, "R5 negative displacement");
    expectStep(16,  1, 5,  32'd2,        "R2 add");
    expectStep(20,  1, 6,  32'd8,        "R2 sub");
    expectStep(24,  1, 7,  32'd4,        "R2 and");
    expectStep(28,  1, 8,  32'd13,       "R2 or");
    expectStep(32,  1, 9,  32'd1,        "R3 slt signed true");
    expectStep(36,  1, 10, 32'd0,        "R3 slt signed false");
    expectStep(40,  1, 11, 32'd17,       "R4 funct high bits ignored");
    expectStep(44,  0, 0,  0,            "R10 write to reg0 dropped");
    expectStep(48,  2, 16, 32'd0,        "R10 reg0 reads zero");
    expectStep(52,  2, 16, 32'd13,       "R6 sw");
    expectStep(56,  1, 12, 32'd13,       "R6 stored word reloads");
    expectStep(60,  1, 1,  32'd10,       "R12 old value read");
    expectStep(64,  1, 1,  32'd20,       "R12 new value next cycle");
    expectStep(68,  0, 0,  0,            "R11 unsupported opcode");
    expectStep(72,  0, 0,  0,            "R8 beq not taken");
    expectStep(76,  0, 0,  0,            "R8 pc+4 after not taken");
    expectStep(88,  0, 0,  0,            "R7 beq forward taken");
    expectStep(100, 0, 0,  0,            "R9 jump");
    expectStep(120, 0, 0,  0,            "R9 jump second");
    expectStep(108, 1, 14, 32'd17,       "R7 beq backward taken");
    expectStep(112, 0, 0,  0,            "R8 sequential");
    expectStep(128, 0, 0,  0,            "R9 jump to end");
    expectStep(128, 0, 0,  0,            "R9 self jump");
    expectStep(128, 0, 0,  0,            "R9 self jump hold");

    rst = 1'b0;
    started = 1;
  end

  // monitor: compare each retired instruction with the scoreboard
  initial begin
    wait (started);
    while (sb.size() > 0) begin
      item_t it;
      #1;
      it = sb.pop_front();
      check(pcOut == it.pc && regWe == (it.kind == 1) && memWe == (it.kind == 2) &&
            (it.kind != 1 || (32'(regWaddr) == it.addr && regWdata == it.data)) &&
            (it.kind != 2 || (memAddr == it.addr && memWdata == it.data)),
            it.tag,
            $sformatf("pc=%0d rwe=%0b ra=%0d rd=%0h mwe=%0b ma=%0d md=%0h",
                      pcOut, regWe, regWaddr, regWdata, memWe, memAddr, memWdata),
            $sformatf("pc=%0d kind=%0d addr=%0d data=%0h",
                      it.pc, it.kind, it.addr, it.data));
      @(negedge clk);
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // watchdog
  initial begin
    #(8 * 5000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule